// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Generator

This block turns the occupancy counts of a UART's receive and transmit FIFOs into the flag bits software polls and into the interrupt sources a driver services. It sits beside the FIFO storage and takes each FIFO's level, the receive push and pop strobes, and the baud-rate tick. From these it produces empty, full and busy flags, three raw interrupt bits, their masked copies and one combined interrupt line.

The receive interrupt is driven by a trigger level set at half the FIFO depth. A receive-timeout interrupt covers characters that sit below that level with no reads. The transmit interrupt is asserted while the transmit FIFO has at least half its depth free. A two-entry register port writes the mask and the write-one-to-clear interrupt-clear register. The receive and transmit interrupts are recomputed from the levels every cycle. The timeout interrupt is latched. All flags and raw bits are registered, so each one follows its inputs with one cycle of latency.

Top module: `uart_irq_status`

## Requirements
- R1: `rx_empty` is 1 in the cycle after `rx_level` is 0, and 0 in the cycle after `rx_level` is nonzero.
- R2: `rx_full` is 1 in the cycle after `rx_level` equals DEPTH, and 0 otherwise.
- R3: `tx_empty` is 1 in the cycle after `tx_level` is 0. `tx_full` and `busy` are both 1 in the cycle after `tx_level` equals DEPTH, and both are 0 when the transmit FIFO is not full.
- R4: Raw bit 0 (receive) is 1 in the cycle after `rx_level` >= DEPTH/2, and 0 in the cycle after the level is below DEPTH/2.
- R5: Raw bit 2 (transmit) is 1 in the cycle after `tx_level` <= DEPTH - DEPTH/2, and 0 otherwise.
- R6: Raw bit 1 (receive timeout) is set in the cycle after the TICKS_PER_BIT*TIMEOUT_BITS-th `baud_tick` counted since the last push or pop, provided `rx_level` is nonzero. Once set it holds until a cycle sees `rx_level` equal to 0 (cleared in the next cycle) or until it is cleared by register write.
- R7: A cycle with `rx_push` or `rx_pop` restarts the timeout count, so earlier ticks do not count. An empty receive FIFO also holds the count at zero.
- R8: A register write with `reg_addr`=1 clears each raw bit whose `reg_wdata` bit is 1, in the next cycle. The timeout bit stays cleared until it fires again. Bits 0 and 2 come back one cycle later if their level condition still holds.
- R9: A register write with `reg_addr`=0 loads `reg_wdata` into the mask in the next cycle. `masked_irq` = raw AND mask, and `irq` is the OR of `masked_irq`.
- R10: During reset and in the cycle after it, both empty flags are 1, every other flag is 0, the raw bits are 0 and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_pop | input | 1 | Character read from the receive FIFO |
| baud_tick | input | 1 | Oversampling tick, TICKS_PER_BIT per bit period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mask, 1 = interrupt clear |
| reg_wdata | input | 3 | Write data; bit 0 receive, bit 1 timeout, bit 2 transmit |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| busy | output | 1 | Transmitter busy (transmit FIFO full) |
| raw_irq | output | 3 | Raw interrupt status |
| masked_irq | output | 3 | Raw status AND mask |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with DEPTH=8, TICKS_PER_BIT=2 and TIMEOUT_BITS=4, so the timeout window is only eight ticks long. With these values it can sweep every pair of receive and transmit levels from 0 to 8, together with every mask value, and so reach each full, empty and half-depth boundary on both sides. The short window also lets it count the ticks exactly around the firing edge, across a restart, while the bit is held, and while the counter is saturated after a clear.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int IRQ_W   = 3;
    localparam int IRQ_RX  = 0;
    localparam int IRQ_RTO = 1;
    localparam int IRQ_TX  = 2;

    typedef enum logic {
        REG_MASK  = 1'b0,
        REG_CLEAR = 1'b1
    } uirq_reg_e;

    typedef struct packed {
        logic rx_empty;
        logic rx_full;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } uirq_flags_t;

    localparam uirq_flags_t FLAGS_RESET = '{
        rx_empty: 1'b1, rx_full: 1'b0,
        tx_empty: 1'b1, tx_full: 1'b0, busy: 1'b0
    };

    function automatic int level_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/uirq_rx_side.sv
module uirq_rx_side #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             clr_trig,
    output logic             empty,
    output logic             full,
    output logic             trig_irq
);
    localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            empty    <= 1'b1;
            full     <= 1'b0;
            trig_irq <= 1'b0;
        end else begin
            empty    <= (level == '0);
            full     <= (level == FULL_L);
            trig_irq <= (level >= HALF_L) && !clr_trig;
        end
    end
endmodule

// File: rtl/uirq_tx_side.sv
module uirq_tx_side #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             clr_space,
    output logic             empty,
    output logic             full,
    output logic             busy,
    output logic             space_irq
);
    localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] SPACE_L = LVL_W'(DEPTH - DEPTH / 2);

    logic at_full;
    assign at_full = (level == FULL_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            empty     <= 1'b1;
            full      <= 1'b0;
            busy      <= 1'b0;
            space_irq <= 1'b0;
        end else begin
            empty     <= (level == '0);
            full      <= at_full;
            busy      <= at_full;
            space_irq <= (level <= SPACE_L) && !clr_space;
        end
    end
endmodule

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic has_data,
    input  logic restart,
    input  logic tick,
    input  logic clr,
    output logic timeout
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] SAT_L  = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;
    logic             fire;

    assign fire = has_data && !restart && tick && (cnt == LAST_L);

    always_ff @(posedge clk) begin
        if (rst || restart || !has_data) begin
            cnt <= '0;
        end else if (tick && cnt != SAT_L) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !has_data) begin
            timeout <= 1'b0;
        end else if (fire) begin
            timeout <= 1'b1;
        end else if (clr) begin
            timeout <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uirq_pkg::*;
#(
    parameter int DEPTH         = 32,
    parameter int TICKS_PER_BIT = 16,
    parameter int TIMEOUT_BITS  = 32,
    localparam int LVL_W        = level_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             baud_tick,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [IRQ_W-1:0] reg_wdata,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             tx_empty,
    output logic             tx_full,
    output logic             busy,
    output logic [IRQ_W-1:0] raw_irq,
    output logic [IRQ_W-1:0] masked_irq,
    output logic             irq
);
    localparam int TO_LIMIT = TICKS_PER_BIT * TIMEOUT_BITS;

    uirq_flags_t      flags;
    logic [IRQ_W-1:0] raw;
    logic [IRQ_W-1:0] mask_q;
    logic [IRQ_W-1:0] clr_vec;

    assign clr_vec = (reg_wr && uirq_reg_e'(reg_addr) == REG_CLEAR) ? reg_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (reg_wr && uirq_reg_e'(reg_addr) == REG_MASK) begin
            mask_q <= reg_wdata;
        end
    end

    uirq_rx_side #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .level    (rx_level),
        .clr_trig (clr_vec[IRQ_RX]),
        .empty    (flags.rx_empty),
        .full     (flags.rx_full),
        .trig_irq (raw[IRQ_RX])
    );

    uirq_tx_side #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .level     (tx_level),
        .clr_space (clr_vec[IRQ_TX]),
        .empty     (flags.tx_empty),
        .full      (flags.tx_full),
        .busy      (flags.busy),
        .space_irq (raw[IRQ_TX])
    );

    uirq_rx_timeout #(.LIMIT(TO_LIMIT)) u_to (
        .clk      (clk),
        .rst      (rst),
        .has_data (rx_level != '0),
        .restart  (rx_push || rx_pop),
        .tick     (baud_tick),
        .clr      (clr_vec[IRQ_RTO]),
        .timeout  (raw[IRQ_RTO])
    );

    assign rx_empty   = flags.rx_empty;
    assign rx_full    = flags.rx_full;
    assign tx_empty   = flags.tx_empty;
    assign tx_full    = flags.tx_full;
    assign busy       = flags.busy;
    assign raw_irq    = raw;
    assign masked_irq = raw & mask_q;
    assign irq        = |masked_irq;
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [2:0]       reg_wdata,
    input logic             rx_empty,
    input logic             rx_full,
    input logic             tx_full,
    input logic             busy,
    input logic [2:0]       raw_irq
);
    logic seen;
    always_ff @(posedge clk) seen <= !rst;

    AST_RX_EMPTY_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !seen)
        rx_empty == ($past(rx_level) == '0));  // R1
    AST_RX_FULL_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !seen)
        rx_full == ($past(rx_level) == LVL_W'(DEPTH)));  // R2
    AST_BUSY_ONLY_FULL: assert property (@(posedge clk) disable iff (rst || !seen)
        busy |-> tx_full);  // R3
    AST_RX_TRIG_LEVEL: assert property (@(posedge clk) disable iff (rst || !seen)
        raw_irq[0] |-> ($past(rx_level) >= LVL_W'(DEPTH / 2)));  // R4
    AST_TX_SPACE_LEVEL: assert property (@(posedge clk) disable iff (rst || !seen)
        raw_irq[2] |-> ($past(tx_level) <= LVL_W'(DEPTH - DEPTH / 2)));  // R5
    AST_RTO_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst || !seen)
        raw_irq[1] |-> ($past(rx_level) != '0));  // R6
    AST_RTO_NO_RISE_EMPTY: assert property (@(posedge clk) disable iff (rst || !seen)
        $rose(raw_irq[1]) |-> !rx_empty);  // R7
endmodule

bind uart_irq_status uirq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_empty  (rx_empty),
    .rx_full   (rx_full),
    .tx_full   (tx_full),
    .busy      (busy),
    .raw_irq   (raw_irq)
);

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int TPB   = 2;
    localparam int TOB   = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int LIMIT = TPB * TOB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
    logic rx_push = 0, rx_pop = 0, baud_tick = 0, reg_wr = 0, reg_addr = 0;
    logic [2:0] reg_wdata = '0;
    logic rx_empty, rx_full, tx_empty, tx_full, busy, irq;
    logic [2:0] raw_irq, masked_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_status #(.DEPTH(DEPTH), .TICKS_PER_BIT(TPB), .TIMEOUT_BITS(TOB)) uut (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .rx_push(rx_push), .rx_pop(rx_pop), .baud_tick(baud_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty),
        .tx_full(tx_full), .busy(busy), .raw_irq(raw_irq),
        .masked_irq(masked_irq), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1; step();
            baud_tick = 0; step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R10 reset state, during reset and after first free cycle
        chk("R10 rx_empty", rx_empty, 1);
        chk("R10 tx_empty", tx_empty, 1);
        chk("R10 flags", {rx_full, tx_full, busy}, 0);
        chk("R10 raw", raw_irq, 0);
        rst = 0;
        step();
        chk("R10 mask", masked_irq, 0);
        chk("R10 irq", irq, 0);

        // sweep of levels and masks: R1 R2 R3 R4 R5 R9
        for (int rl = 0; rl <= DEPTH; rl++) begin
            for (int tl = 0; tl <= DEPTH; tl++) begin
                int m;
                int er;
                m = (rl * 3 + tl * 5) % 8;
                rx_level = LVL_W'(rl); tx_level = LVL_W'(tl);
                reg_wr = 1; reg_addr = 0; reg_wdata = 3'(m);
                step();
                reg_wr = 0;
                er = ((rl >= DEPTH / 2) ? 1 : 0) | ((tl <= DEPTH - DEPTH / 2) ? 4 : 0);
                chk("R1 rx_empty", rx_empty, rl == 0);
                chk("R2 rx_full", rx_full, rl == DEPTH);
                chk("R3 tx_empty", tx_empty, tl == 0);
                chk("R3 tx_full", tx_full, tl == DEPTH);
                chk("R3 busy", busy, tl == DEPTH);
                chk("R4 rx bit", raw_irq[0], er & 1);
                chk("R5 tx bit", raw_irq[2], (er >> 2) & 1);
                chk("R9 masked", masked_irq, er & m);
                chk("R9 irq", irq, (er & m) != 0);
            end
        end

        // timeout: R6 R7
        reg_wr = 1; reg_addr = 0; reg_wdata = 3'b010;
        tx_level = LVL_W'(DEPTH);
        rx_level = 1; rx_push = 1; step();
        reg_wr = 0; rx_push = 0;
        ticks(LIMIT - 1);
        chk("R6 before limit", raw_irq[1], 0);
        rx_pop = 1; step(); rx_pop = 0;     // restart, level stays 1
        ticks(LIMIT - 1);
        chk("R7 restart discards ticks", raw_irq[1], 0);
        ticks(1);
        chk("R6 fires at limit", raw_irq[1], 1);
        chk("R9 irq from timeout", irq, 1);
        ticks(3);
        chk("R6 holds", raw_irq[1], 1);

        // R8 clear timeout, stays clear while counter saturated
        reg_wr = 1; reg_addr = 1; reg_wdata = 3'b010; step(); reg_wr = 0;
        chk("R8 timeout cleared", raw_irq[1], 0);
        ticks(2 * LIMIT);
        chk("R8 stays cleared", raw_irq[1], 0);

        // R6 cleared by empty FIFO
        rx_push = 1; step(); rx_push = 0;
        ticks(LIMIT);
        chk("R6 refire", raw_irq[1], 1);
        rx_level = 0; step();
        chk("R6 empty clears", raw_irq[1], 0);
        chk("R7 empty holds count", raw_irq[1], 0);
        rx_level = 1; ticks(LIMIT);
        chk("R7 empty reset count", raw_irq[1], 1);
        rx_level = 0; step();

        // R8 level bits drop one cycle then return
        rx_level = LVL_W'(DEPTH); tx_level = 0; step();
        chk("R8 pre rx", raw_irq[0], 1);
        chk("R8 pre tx", raw_irq[2], 1);
        reg_wr = 1; reg_addr = 1; reg_wdata = 3'b101; step(); reg_wr = 0;
        chk("R8 rx dropped", raw_irq[0], 0);
        chk("R8 tx dropped", raw_irq[2], 0);
        step();
        chk("R8 rx back", raw_irq[0], 1);
        chk("R8 tx back", raw_irq[2], 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule